// File: doc/BRIEF.md
# External Memory Bus Strobe Controller

This block runs one external memory access at a time for a 16-bit controller and drives the control strobes of the external bus. An internal master presents a request with an address, a read/write flag, byte enables and write data. The block accepts the request when it is idle and steps through three phases: an address phase, a command phase in which the strobe is active, and a one-clock release phase. During the release phase it returns a one-clock done pulse together with the read data.

The configuration inputs are captured at the moment a request is accepted. They select between two addressing schemes. In the first, the address and data share one bus and the address is marked by a latch-enable pulse. In the second, the address has its own bus. The configuration also selects an 8-bit or 16-bit data width and one of two write-strobe schemes. In the plain scheme, one strobe marks every write and a companion pin acts as the high-byte enable. In the split scheme, the two pins are separate low-byte and high-byte write strobes. The length of the command phase comes from a programmed count. An optional ready input can stretch the command phase with wait states.

Top module: `xbus_strobe_ctrl`

## Requirements
- R1: While reset is applied, and after it is released with no request, `busy_o`, `done_o`, `ale_o`, `addr_oe_o` and `ad_oe_o` are 0 and the active-low strobes `rd_n_o`, `wr_n_o` and `hb_n_o` are 1.
- R2: An accepted access keeps `busy_o` high for one address clock, then the command clocks, then one release clock. `done_o` is high only in the release clock. The strobes are all inactive during that release clock.
- R3: With `cfg_mux`=1, `ale_o` is high for exactly the address clock, `ad_o` carries the address with `ad_oe_o`=1 in that clock, and `addr_oe_o` stays 0.
- R4: With `cfg_mux`=0, `ale_o` stays 0, `addr_o` carries the address with `addr_oe_o`=1 from the address clock through the release clock, and `ad_oe_o` is 0 in the address clock.
- R5: A read drives `rd_n_o` low for every command clock. `rdata_o` holds `ad_i` as sampled on the clock edge that ends the command phase. On an 8-bit bus (`cfg_bus16`=0), bits 15:8 of `rdata_o` are zero.
- R6: In the plain write scheme (`cfg_wlow`=0), every write drives `wr_n_o` low for every command clock. Whenever a write strobe is low, `ad_o` carries the write data with `ad_oe_o`=1.
- R7: In the plain scheme on a 16-bit bus, `hb_n_o` is low through the address and command clocks when byte enable bit 1 (high byte) is set, for both reads and writes. On an 8-bit bus `hb_n_o` stays high.
- R8: In the split scheme (`cfg_wlow`=1) on a 16-bit bus, `wr_n_o` is low in the command clocks only for writes with byte enable bit 0 (low byte) set. `hb_n_o` is low in the command clocks only for writes with bit 1 set. Reads drive neither pin.
- R9: In the split scheme on an 8-bit bus, `wr_n_o` is low in the command clocks of every write and `hb_n_o` stays high.
- R10: With `cfg_rdy_en`=0, the command phase lasts exactly `cfg_len`+1 clocks (`cfg_len` 0..3 gives 1..4), whatever level `ready_i` has.
- R11: With `cfg_rdy_en`=1, the command phase ends only on an edge where the programmed count has run out and `ready_i` is low. Each clock in which `ready_i` is still high at that point adds one wait clock.
- R12: A request presented while an access is in progress is ignored: it starts no access and produces no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request; taken when the block is idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_be | input | 2 | Byte enables; bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| cfg_mux | input | 1 | 1 = shared address/data bus, 0 = separate address bus |
| cfg_bus16 | input | 1 | 1 = 16-bit data bus, 0 = 8-bit |
| cfg_wlow | input | 1 | 1 = split low/high write strobes, 0 = plain write strobe |
| cfg_rdy_en | input | 1 | Enables wait states from ready_i |
| cfg_len | input | 2 | Command clocks minus one |
| ready_i | input | 1 | High requests wait states |
| ad_i | input | 16 | Data read from the shared bus |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read data, valid with done_o |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe or low-byte write strobe, active low |
| hb_n_o | output | 1 | High-byte enable or high-byte write strobe, active low |
| addr_o | output | 16 | Separate address bus |
| addr_oe_o | output | 1 | Drive enable for addr_o |
| ad_o | output | 16 | Shared address/data bus output |
| ad_oe_o | output | 1 | Drive enable for ad_o |

## Verification
The request is taken on the first clock edge after `req_valid` rises while the block is idle. The address clock follows that edge. The command phase then runs for `cfg_len`+1 clocks plus any wait clocks, and the done pulse comes in the clock after that, so `busy_o` lasts `cfg_len`+3+waits clocks. The driver computes that count, the strobe clock counts for each pin and the read data for each access, and pushes them into a queue. It steers `ready_i` clock by clock from the same count. A monitor samples on falling edges, away from the active edge, and tallies each strobe's low clocks and the bus contents. On each done pulse it compares the tallies with the front of the queue, so any shift of a strobe or of the done pulse by one clock changes a tally.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  parameter int XB_LEN_W = 2;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_ADDR = 2'd1,
    XS_CMD  = 2'd2,
    XS_REL  = 2'd3
  } xstate_e;

  typedef struct packed {
    logic                mux;
    logic                bus16;
    logic                wlow;
    logic                rdy_en;
    logic [XB_LEN_W-1:0] len;
  } xcfg_t;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int LEN_W = XB_LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rdy_en,
  input  logic             ready,
  input  logic [LEN_W-1:0] len,
  output xstate_e          state_o,
  output logic             cmd_last_o
);
  xstate_e          st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             cmd_last;

  always_comb begin
    cmd_last = (st_q == XS_CMD) && (cnt_q == '0) && !(rdy_en && ready);
    st_d     = st_q;
    unique case (st_q)
      XS_IDLE: if (start) st_d = XS_ADDR;
      XS_ADDR: st_d = XS_CMD;
      XS_CMD:  if (cmd_last) st_d = XS_REL;
      XS_REL:  st_d = XS_IDLE;
      default: st_d = XS_IDLE;
    endcase
    cnt_en = (st_q == XS_ADDR) || ((st_q == XS_CMD) && (cnt_q != '0));
    cnt_d  = (st_q == XS_ADDR) ? len : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= XS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state_o    = st_q;
  assign cmd_last_o = cmd_last;

  p_rel_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_REL) |=> (st_q == XS_IDLE));
  p_no_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_CMD && cnt_q == '0 && !rdy_en) |=> (st_q == XS_REL));
  p_wait_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_CMD && rdy_en && ready) |=> (st_q == XS_CMD));
endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath
  import xbus_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 req_write,
  input  logic [BUS_W-1:0]     req_addr,
  input  logic [BUS_W/8-1:0]   req_be,
  input  logic [BUS_W-1:0]     req_wdata,
  input  xcfg_t                cfg_i,
  input  xstate_e              state_i,
  input  logic                 cap_i,
  input  logic [BUS_W-1:0]     ad_i,
  output logic                 wr_q_o,
  output logic [BUS_W/8-1:0]   be_q_o,
  output xcfg_t                cfg_q_o,
  output logic [BUS_W-1:0]     addr_o,
  output logic                 addr_oe_o,
  output logic [BUS_W-1:0]     ad_o,
  output logic                 ad_oe_o,
  output logic [BUS_W-1:0]     rdata_o,
  output logic                 done_o
);
  localparam int LANES = BUS_W / 8;

  logic               wr_q;
  logic [LANES-1:0]   be_q;
  logic [BUS_W-1:0]   addr_q, wdata_q, rdata_q;
  xcfg_t              cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      cfg_q   <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      be_q    <= req_be;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      cfg_q   <= cfg_i;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_on;
    assign lane_on = (l == 0) || cfg_q.bus16;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q[l*8 +: 8] <= 8'h00;
      else if (cap_i) rdata_q[l*8 +: 8] <= lane_on ? ad_i[l*8 +: 8] : 8'h00;
    end
  end

  logic in_addr, active, data_ph;
  always_comb begin
    in_addr   = (state_i == XS_ADDR);
    active    = (state_i != XS_IDLE);
    data_ph   = (state_i == XS_CMD) || (state_i == XS_REL);
    addr_o    = addr_q;
    addr_oe_o = active && !cfg_q.mux;
    ad_o      = (in_addr && cfg_q.mux) ? addr_q : wdata_q;
    ad_oe_o   = (in_addr && cfg_q.mux) || (data_ph && wr_q);
    done_o    = (state_i == XS_REL);
  end

  assign wr_q_o  = wr_q;
  assign be_q_o  = be_q;
  assign cfg_q_o = cfg_q;
  assign rdata_o = rdata_q;

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i != XS_IDLE && state_i != XS_REL) |=> $stable(cfg_q));
endmodule

// File: rtl/xbus_strobe.sv
module xbus_strobe
  import xbus_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xstate_e          state_i,
  input  logic             wr_q,
  input  logic [LANES-1:0] be_q,
  input  xcfg_t            cfg_q,
  output logic             ale_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic             hb_n_o
);
  logic cmd, adr, hi_be, lo_be;

  always_comb begin
    cmd   = (state_i == XS_CMD);
    adr   = (state_i == XS_ADDR);
    lo_be = be_q[0];
    hi_be = be_q[LANES-1] && cfg_q.bus16;
    ale_o  = adr && cfg_q.mux;
    rd_n_o = !(cmd && !wr_q);
    if (cfg_q.wlow) begin
      wr_n_o = !(cmd && wr_q && (lo_be || !cfg_q.bus16));
      hb_n_o = !(cmd && wr_q && hi_be);
    end else begin
      wr_n_o = !(cmd && wr_q);
      hb_n_o = !((adr || cmd) && hi_be);
    end
  end

  p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));
  p_split_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.wlow && !rd_n_o) |-> hb_n_o);
endmodule

// File: rtl/xbus_strobe_ctrl.sv
module xbus_strobe_ctrl
  import xbus_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int LEN_W = XB_LEN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [BUS_W-1:0]   req_addr,
  input  logic [BUS_W/8-1:0] req_be,
  input  logic [BUS_W-1:0]   req_wdata,
  input  logic               cfg_mux,
  input  logic               cfg_bus16,
  input  logic               cfg_wlow,
  input  logic               cfg_rdy_en,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               ready_i,
  input  logic [BUS_W-1:0]   ad_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [BUS_W-1:0]   rdata_o,
  output logic               ale_o,
  output logic               rd_n_o,
  output logic               wr_n_o,
  output logic               hb_n_o,
  output logic [BUS_W-1:0]   addr_o,
  output logic               addr_oe_o,
  output logic [BUS_W-1:0]   ad_o,
  output logic               ad_oe_o
);
  localparam int LANES = BUS_W / 8;

  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  xstate_e          state;
  logic             cmd_last, accept, wr_q;
  logic [LANES-1:0] be_q;
  xcfg_t            cfg_in, cfg_q;

  always_comb begin
    cfg_in.mux    = cfg_mux;
    cfg_in.bus16  = cfg_bus16;
    cfg_in.wlow   = cfg_wlow;
    cfg_in.rdy_en = cfg_rdy_en;
    cfg_in.len    = cfg_len;
    accept        = req_valid && (state == XS_IDLE);
    busy_o        = (state != XS_IDLE);
  end

  xbus_seq #(.LEN_W(LEN_W)) seq_i (
    .clk(clk), .rst_n(rst_s_n), .start(accept), .rdy_en(cfg_q.rdy_en),
    .ready(ready_i), .len(cfg_q.len), .state_o(state), .cmd_last_o(cmd_last)
  );

  xbus_dpath #(.BUS_W(BUS_W)) dpath_i (
    .clk(clk), .rst_n(rst_s_n), .accept(accept), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .cfg_i(cfg_in), .state_i(state), .cap_i(cmd_last), .ad_i(ad_i),
    .wr_q_o(wr_q), .be_q_o(be_q), .cfg_q_o(cfg_q), .addr_o(addr_o),
    .addr_oe_o(addr_oe_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .rdata_o(rdata_o), .done_o(done_o)
  );

  xbus_strobe #(.LANES(LANES)) strobe_i (
    .clk(clk), .rst_n(rst_s_n), .state_i(state), .wr_q(wr_q), .be_q(be_q),
    .cfg_q(cfg_q), .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .hb_n_o(hb_n_o)
  );

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |=> !done_o);
  p_rd_rise_done_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rd_n_o) |-> done_o);
  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    ale_o |=> (!ale_o && busy_o));
  p_bus_excl_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    ale_o |-> !addr_oe_o);
  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/xbus_strobe_ctrl_tb_top.sv
module xbus_strobe_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        cfg_mux = 1'b0, cfg_bus16 = 1'b1, cfg_wlow = 1'b0, cfg_rdy_en = 1'b0;
  logic [1:0]  cfg_len = '0;
  logic        ready_i = 1'b0;
  logic [15:0] rd_val = '0;
  logic [15:0] ad_i;
  logic        busy_o, done_o, ale_o, rd_n_o, wr_n_o, hb_n_o, addr_oe_o, ad_oe_o;
  logic [15:0] rdata_o, addr_o, ad_o;

  always #10 clk = ~clk;

  assign ad_i = ad_oe_o ? ad_o : rd_val;

  xbus_strobe_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .cfg_mux(cfg_mux), .cfg_bus16(cfg_bus16), .cfg_wlow(cfg_wlow),
    .cfg_rdy_en(cfg_rdy_en), .cfg_len(cfg_len), .ready_i(ready_i), .ad_i(ad_i),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .ale_o(ale_o),
    .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .hb_n_o(hb_n_o), .addr_o(addr_o),
    .addr_oe_o(addr_oe_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o)
  );

  typedef struct {
    bit        wr, mux, bus16, wlow, ren;
    bit [15:0] addr, wdata, rdata;
    int        busy_c, rd_c, wr_c, hb_c, ale_c;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0, issued = 0, seen = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor state
  int        m_busy = 0, m_rd = 0, m_wr = 0, m_hb = 0, m_ale = 0;
  bit [15:0] m_ale_addr = '0;
  bit        m_first_adoe = 0, m_data_bad = 0, m_addr_bad = 0, m_rel_bad = 0;

  always @(negedge clk) begin
    if (rst_n && busy_o) begin
      m_busy++;
      if (!rd_n_o) m_rd++;
      if (!wr_n_o) m_wr++;
      if (!hb_n_o) m_hb++;
      if (ale_o) begin m_ale++; m_ale_addr = ad_o; end
      if (m_busy == 1) m_first_adoe = ad_oe_o;
      if (q.size() > 0) begin
        if (q[0].wr && (!wr_n_o || (q[0].wlow && !hb_n_o)) &&
            (!ad_oe_o || ad_o != q[0].wdata)) m_data_bad = 1;
        if (!q[0].mux && (!addr_oe_o || addr_o != q[0].addr)) m_addr_bad = 1;
        if (q[0].mux && addr_oe_o) m_addr_bad = 1;
      end
      if (done_o && (!rd_n_o || !wr_n_o || !hb_n_o)) m_rel_bad = 1;
    end
    if (rst_n && done_o) begin
      seen++;
      if (q.size() == 0) begin
        chk(0, "R12 unexpected done pulse", 1, 0);
      end else begin
        exp_t e;
        string lt, wt, ht, at;
        e = q.pop_front();
        lt = e.ren ? "R11 busy length" : "R10 busy length";
        wt = e.wlow ? (e.bus16 ? "R8 wr_n clocks" : "R9 wr_n clocks") : "R6 wr_n clocks";
        ht = e.wlow ? (e.bus16 ? "R8 hb_n clocks" : "R9 hb_n clocks") : "R7 hb_n clocks";
        at = e.mux ? "R3 address" : "R4 address";
        chk(m_busy == e.busy_c, lt, m_busy, e.busy_c);
        chk(m_busy == e.busy_c, "R2 done position", m_busy, e.busy_c);
        chk(!m_rel_bad, "R2 strobes in release", 1, 0);
        chk(m_rd == e.rd_c, "R5 rd_n clocks", m_rd, e.rd_c);
        chk(m_wr == e.wr_c, wt, m_wr, e.wr_c);
        chk(m_hb == e.hb_c, ht, m_hb, e.hb_c);
        chk(m_ale == e.ale_c, "R3 ale clocks", m_ale, e.ale_c);
        if (e.mux) chk(m_ale_addr == e.addr, at, m_ale_addr, e.addr);
        else begin
          chk(!m_addr_bad, at, m_addr_bad, 0);
          chk(!m_first_adoe, "R4 ad_oe in address clock", m_first_adoe, 0);
        end
        if (e.wr) chk(!m_data_bad, "R6 write data on bus", m_data_bad, 0);
        else chk(rdata_o == e.rdata, "R5 read data", rdata_o, e.rdata);
      end
      m_busy = 0; m_rd = 0; m_wr = 0; m_hb = 0; m_ale = 0;
      m_data_bad = 0; m_addr_bad = 0; m_rel_bad = 0; m_first_adoe = 0;
    end
  end

  task automatic do_access(input bit wr, input bit [15:0] a, input bit [1:0] be,
                           input bit [15:0] wd, input bit [15:0] rv,
                           input bit mux, input bit b16, input bit wlow,
                           input bit ren, input int len, input int w, input bit hold);
    exp_t e;
    int cl, i;
    cl = len + 1 + (ren ? w : 0);
    e.wr = wr; e.mux = mux; e.bus16 = b16; e.wlow = wlow; e.ren = ren;
    e.addr = a; e.wdata = wd;
    e.rdata = b16 ? rv : {8'h00, rv[7:0]};
    e.busy_c = cl + 2;
    e.rd_c = wr ? 0 : cl;
    e.wr_c = (wr && (!wlow || !b16 || be[0])) ? cl : 0;
    if (!wlow) e.hb_c = (b16 && be[1]) ? cl + 1 : 0;
    else       e.hb_c = (wr && b16 && be[1]) ? cl : 0;
    e.ale_c = mux ? 1 : 0;
    q.push_back(e);
    issued++;
    cfg_mux = mux; cfg_bus16 = b16; cfg_wlow = wlow; cfg_rdy_en = ren;
    cfg_len = 2'(len);
    req_write = wr; req_addr = a; req_be = be; req_wdata = wd; rd_val = rv;
    req_valid = 1'b1; ready_i = 1'b1;
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    // R10: with waits disabled ready_i stays high and must be ignored
    i = -1;
    while (busy_o) begin
      ready_i = ren ? (i < len + w) : 1'b1;
      if (done_o) req_valid = 1'b0;
      @(negedge clk);
      i++;
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(!busy_o && !done_o && !ale_o && !addr_oe_o && !ad_oe_o &&
        rd_n_o && wr_n_o && hb_n_o, "R1 outputs in reset", 0, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o && !ale_o && !addr_oe_o && !ad_oe_o &&
        rd_n_o && wr_n_o && hb_n_o, "R1 outputs after reset", 0, 1);

    do_access(0, 16'h1234, 2'b11, 16'h0000, 16'hBEEF, 1, 1, 0, 0, 0, 0, 0);
    do_access(1, 16'h2468, 2'b11, 16'hCAFE, 16'h0000, 1, 1, 0, 0, 1, 0, 0);
    do_access(0, 16'h0F0F, 2'b10, 16'h0000, 16'h5A5A, 0, 1, 0, 0, 3, 0, 0);
    do_access(1, 16'h00A1, 2'b01, 16'h0077, 16'h0000, 0, 0, 0, 0, 2, 0, 0);
    do_access(1, 16'h3000, 2'b01, 16'h1111, 16'h0000, 1, 1, 1, 0, 0, 0, 0);
    do_access(1, 16'h3002, 2'b10, 16'h2222, 16'h0000, 1, 1, 1, 0, 1, 0, 0);
    do_access(1, 16'h3004, 2'b11, 16'h3333, 16'h0000, 0, 1, 1, 0, 2, 0, 0);
    do_access(1, 16'h3006, 2'b01, 16'h0044, 16'h0000, 1, 0, 1, 0, 0, 0, 0);
    do_access(0, 16'h3008, 2'b11, 16'h0000, 16'h9876, 1, 1, 1, 0, 1, 0, 0);
    do_access(0, 16'h4000, 2'b01, 16'h0000, 16'hABCD, 1, 0, 0, 0, 0, 0, 0);
    do_access(0, 16'h5000, 2'b11, 16'h0000, 16'h1357, 1, 1, 0, 1, 1, 3, 0);
    do_access(1, 16'h5002, 2'b11, 16'h8642, 16'h0000, 0, 1, 0, 1, 0, 2, 0);
    do_access(0, 16'h5004, 2'b11, 16'h0000, 16'h0246, 0, 1, 1, 1, 3, 0, 0);
    do_access(0, 16'h6000, 2'b11, 16'h0000, 16'hFACE, 1, 1, 0, 0, 2, 0, 0);
    // R12: request held high for the whole access
    do_access(0, 16'h7000, 2'b11, 16'h0000, 16'h7777, 0, 1, 0, 0, 1, 0, 1);
    repeat (6) @(negedge clk);
    chk(!busy_o, "R12 no access started while busy", busy_o, 0);
    chk(seen == issued, "R12 done count", seen, issued);
    chk(q.size() == 0, "R2 all accesses completed", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule